// File: doc/BRIEF.md
# DAC Power-Up Configuration Sequencer

This block brings a high-speed DAC into service after reset. On a start pulse it drives a byte-wide register request port. It first pulses a soft-reset bit. It then loads the clock common-mode and phase-controller settings. Next it runs two lock-acquisition loops, first the phase (mu) controller and then the data-receiver delay loop. Each loop is retried a bounded number of times, and each try is limited by a poll timeout.

When both locks are reached, the block turns a requested full-scale output current, given in microamps, into a 10-bit code. It writes that code as a low byte plus two high bits merged into a second register. The result is reported on level outputs: `done` for success, or `error` together with a code that names the stage that failed. Both levels hold until the next start.

The register port carries one transaction at a time. A request stays asserted and stable until the target returns a one-cycle acknowledge. Read data is taken in the acknowledge cycle.

Top module: `dac_bringup_seq`

## Requirements
- R1: After reset, `done`, `error`, `err_code` and `bus_req` are 0. A `start` pulse that arrives while a sequence is running has no effect.
- R2: The sequence opens by reading register 0x00 and writing it back with bit 5 set and the other bits kept. It then waits at least RST_HOLD_CYC cycles, and writes the same register again with bit 5 cleared and the other bits kept.
- R3: The configuration writes follow the soft reset in this exact order: 0x0F to 0x22, 0x0F to 0x23, 0x30 to 0x24, 0x80 to 0x25, 0x44 to 0x27, 0x6C to 0x28.
- R4: Each mu-lock try writes 0xCB to 0x29. It then sets bit 0 of 0x26 by read-modify-write, and reads 0x2A repeatedly until bit 0 reads 1, ignoring the other bits.
- R5: A try is abandoned only after its polling has run for POLL_TIMEOUT_CYC cycles without a lock.
- R6: Each loop makes at most 3 tries. If all mu tries time out, the block stops with `error`=1 and `err_code`=1, and it writes no receiver register.
- R7: Each receiver try does three writes. It sets bits 3:0 of 0x13 to 2 by read-modify-write, keeping bits 7:4. It then writes 0x00 to 0x10, and then sets bits 1:0 of 0x10 by read-modify-write.
- R8: The receiver counts as locked only when 0x21 reads exactly 0x09. If all three receiver tries fail, the block ends with `err_code`=2.
- R9: A full-scale request outside 8580 to 31700 µA ends the sequence with `err_code`=3, and neither 0x06 nor 0x07 is written.
- R10: For a valid request I, code = round((10·I − 85800)/226). Bits 7:0 of the code are written to 0x06. Bits 9:8 are merged into bits 1:0 of 0x07 by read-modify-write, keeping bits 7:2.
- R11: When `fsc_valid` is low at start, no current write happens and `done` rises after receiver lock.
- R12: A request is held with stable address, direction and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a bring-up sequence when idle |
| fsc_valid | input | 1 | A full-scale request is supplied (sampled at start) |
| fsc_ua | input | 16 | Requested full-scale current in µA (sampled at start) |
| bus_req | output | 1 | Register transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge from the register target |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| done | output | 1 | Sequence completed successfully |
| error | output | 1 | Sequence stopped on a failure |
| err_code | output | 2 | 0 none, 1 mu lock, 2 receiver lock, 3 current out of range |

## Verification
A wrong step index or a wrong retry target shows at the port as a write sequence that differs from the expected order. This becomes visible within one transaction of the fault, and the bench compares every logged write against the required order. A retry counter or poll timer that is off shows up as the wrong number of 0xCB or 0x13 writes. It can also show as a gap between tries shorter than the timeout, which the bench measures on the write timestamps. A slip in the code arithmetic appears directly in the bytes written to 0x06 and 0x07, which are checked at both ends of the range and at a value that rounds up.

// File: rtl/dac_bringup_pkg.sv
package dac_bringup_pkg;

    typedef enum logic [2:0] {
        K_WR, K_RMW, K_WAIT, K_POLL, K_FSC, K_END
    } kind_e;

    typedef enum logic [1:0] {
        E_NONE = 2'd0, E_MU = 2'd1, E_RX = 2'd2, E_FSC = 2'd3
    } err_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] addr;
        logic [7:0] mask;
        logic [7:0] val;
        logic [4:0] loop_at;
        err_e       fail;
    } step_t;

    localparam int STEP_W   = 5;
    localparam int MU_LOOP  = 9;
    localparam int RX_LOOP  = 12;

    function automatic step_t mk(kind_e k, logic [7:0] a, logic [7:0] m,
                                 logic [7:0] v, int lp, err_e f);
        step_t s;
        s.kind    = k;
        s.addr    = a;
        s.mask    = m;
        s.val     = v;
        s.loop_at = 5'(lp);
        s.fail    = f;
        return s;
    endfunction

    // Bring-up program; retry targets and failure codes travel with each poll step.
    function automatic step_t step_at(logic [STEP_W-1:0] idx, logic [9:0] code);
        step_t s;
        case (idx)
            5'd0:  s = mk(K_RMW,  8'h00, 8'h20, 8'h20, 0, E_NONE);
            5'd1:  s = mk(K_WAIT, 8'h00, 8'h00, 8'h00, 0, E_NONE);
            5'd2:  s = mk(K_RMW,  8'h00, 8'h20, 8'h00, 0, E_NONE);
            5'd3:  s = mk(K_WR,   8'h22, 8'hFF, 8'h0F, 0, E_NONE);
            5'd4:  s = mk(K_WR,   8'h23, 8'hFF, 8'h0F, 0, E_NONE);
            5'd5:  s = mk(K_WR,   8'h24, 8'hFF, 8'h30, 0, E_NONE);
            5'd6:  s = mk(K_WR,   8'h25, 8'hFF, 8'h80, 0, E_NONE);
            5'd7:  s = mk(K_WR,   8'h27, 8'hFF, 8'h44, 0, E_NONE);
            5'd8:  s = mk(K_WR,   8'h28, 8'hFF, 8'h6C, 0, E_NONE);
            5'd9:  s = mk(K_WR,   8'h29, 8'hFF, 8'hCB, 0, E_NONE);
            5'd10: s = mk(K_RMW,  8'h26, 8'h01, 8'h01, 0, E_NONE);
            5'd11: s = mk(K_POLL, 8'h2A, 8'h01, 8'h01, MU_LOOP, E_MU);
            5'd12: s = mk(K_RMW,  8'h13, 8'h0F, 8'h02, 0, E_NONE);
            5'd13: s = mk(K_WR,   8'h10, 8'hFF, 8'h00, 0, E_NONE);
            5'd14: s = mk(K_RMW,  8'h10, 8'h03, 8'h03, 0, E_NONE);
            5'd15: s = mk(K_POLL, 8'h21, 8'hFF, 8'h09, RX_LOOP, E_RX);
            5'd16: s = mk(K_FSC,  8'h00, 8'h00, 8'h00, 0, E_NONE);
            5'd17: s = mk(K_WR,   8'h06, 8'hFF, code[7:0], 0, E_NONE);
            5'd18: s = mk(K_RMW,  8'h07, 8'h03, {6'd0, code[9:8]}, 0, E_NONE);
            default: s = mk(K_END, 8'h00, 8'h00, 8'h00, 0, E_NONE);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (!run)
            count_d = '0;
        else if (count_q != W'(LIMIT))
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = (count_q == W'(LIMIT));

    // R5: the window restarts whenever the timer is released
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired);
endmodule

// File: rtl/fsc_code_calc.sv
module fsc_code_calc #(
    parameter int unsigned MIN_UA = 8580,
    parameter int unsigned MAX_UA = 31700,
    parameter int unsigned STEP   = 226
) (
    input  logic [15:0] ua,
    output logic        in_range,
    output logic [9:0]  code
);
    localparam int unsigned BASE = MIN_UA * 10;
    localparam int unsigned HALF = STEP / 2;

    logic [31:0] num;

    always_comb begin
        in_range = (32'(ua) >= MIN_UA) && (32'(ua) <= MAX_UA);
        num      = in_range ? (32'(ua) * 32'd10 - BASE + HALF) : 32'd0;
        code     = 10'(num / STEP);
    end
endmodule

// File: rtl/dac_bringup_seq.sv
module dac_bringup_seq
    import dac_bringup_pkg::*;
#(
    parameter int unsigned RST_HOLD_CYC     = 4,
    parameter int unsigned POLL_TIMEOUT_CYC = 100000,
    parameter int unsigned MAX_TRIES        = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        fsc_valid,
    input  logic [15:0] fsc_ua,
    output logic        bus_req,
    output logic        bus_we,
    output logic [7:0]  bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic        bus_ack,
    input  logic [7:0]  bus_rdata,
    output logic        done,
    output logic        error,
    output logic [1:0]  err_code
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_HOLD} fsm_e;

    typedef struct packed {
        fsm_e              fsm;
        logic [STEP_W-1:0] step;
        logic [TRY_W-1:0]  tries;
        logic              req;
        logic              we;
        logic [7:0]        addr;
        logic [7:0]        wdata;
        logic              done;
        logic              error;
        err_e              err;
        logic [15:0]       ua;
        logic              ua_vld;
    } regs_t;

    regs_t d, q;
    step_t cur;
    logic  fsc_ok, poll_expired, hold_expired, poll_run, hold_run;
    logic [9:0] fsc_code;

    fsc_code_calc u_code (
        .ua       (q.ua),
        .in_range (fsc_ok),
        .code     (fsc_code)
    );

    assign cur      = step_at(q.step, fsc_code);
    assign poll_run = (q.fsm == S_RD) && (cur.kind == K_POLL);
    assign hold_run = (q.fsm == S_HOLD);

    cycle_timer #(.LIMIT(POLL_TIMEOUT_CYC)) u_poll_tmr (
        .clk (clk), .rst_n (rst_n), .run (poll_run), .expired (poll_expired)
    );

    cycle_timer #(.LIMIT(RST_HOLD_CYC)) u_hold_tmr (
        .clk (clk), .rst_n (rst_n), .run (hold_run), .expired (hold_expired)
    );

    always_comb begin
        d = q;
        unique case (q.fsm)
            S_IDLE: begin
                if (start) begin
                    d.fsm    = S_FETCH;
                    d.step   = '0;
                    d.tries  = '0;
                    d.done   = 1'b0;
                    d.error  = 1'b0;
                    d.err    = E_NONE;
                    d.ua     = fsc_ua;
                    d.ua_vld = fsc_valid;
                end
            end
            S_FETCH: begin
                case (cur.kind)
                    K_WR: begin
                        d.req   = 1'b1;
                        d.we    = 1'b1;
                        d.addr  = cur.addr;
                        d.wdata = cur.val;
                        d.fsm   = S_WR;
                    end
                    K_RMW, K_POLL: begin
                        d.req  = 1'b1;
                        d.we   = 1'b0;
                        d.addr = cur.addr;
                        d.fsm  = S_RD;
                    end
                    K_WAIT: d.fsm = S_HOLD;
                    K_FSC: begin
                        if (!q.ua_vld) begin
                            d.done = 1'b1;
                            d.fsm  = S_IDLE;
                        end else if (!fsc_ok) begin
                            d.error = 1'b1;
                            d.err   = E_FSC;
                            d.fsm   = S_IDLE;
                        end else begin
                            d.step = q.step + 1'b1;
                        end
                    end
                    default: begin
                        d.done = 1'b1;
                        d.fsm  = S_IDLE;
                    end
                endcase
            end
            S_WR: begin
                if (bus_ack) begin
                    d.req  = 1'b0;
                    d.we   = 1'b0;
                    d.step = q.step + 1'b1;
                    d.fsm  = S_FETCH;
                end
            end
            S_RD: begin
                if (bus_ack) begin
                    if (cur.kind == K_RMW) begin
                        d.we    = 1'b1;
                        d.wdata = (bus_rdata & ~cur.mask) | (cur.val & cur.mask);
                        d.fsm   = S_WR;
                    end else if ((bus_rdata & cur.mask) == cur.val) begin
                        d.req   = 1'b0;
                        d.tries = '0;
                        d.step  = q.step + 1'b1;
                        d.fsm   = S_FETCH;
                    end else if (poll_expired) begin
                        d.req = 1'b0;
                        if (q.tries == TRY_W'(MAX_TRIES - 1)) begin
                            d.error = 1'b1;
                            d.err   = cur.fail;
                            d.fsm   = S_IDLE;
                        end else begin
                            d.tries = q.tries + 1'b1;
                            d.step  = cur.loop_at;
                            d.fsm   = S_FETCH;
                        end
                    end
                    // otherwise the request stays up and the poll read repeats
                end
            end
            S_HOLD: begin
                if (hold_expired) begin
                    d.step = q.step + 1'b1;
                    d.fsm  = S_FETCH;
                end
            end
            default: d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;
    assign done      = q.done;
    assign error     = q.error;
    assign err_code  = q.err;

    // R12: an unacknowledged request does not move
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    // R1: success and failure never reported together
    a_r1_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R6: a failure always carries a cause
    a_r6_err_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != 2'd0));

    // R6: the retry count stays under the try limit
    a_r6_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries < TRY_W'(MAX_TRIES));

    // R9: a range failure leaves the bus quiet
    a_r9_quiet_on_range_err: assert property (@(posedge clk) disable iff (!rst_n)
        (error && err_code == 2'd3) |-> !bus_req);

    // R1: a finished sequence issues no further transactions
    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fsm == S_IDLE) |-> !bus_req);
endmodule

// File: tb/dac_bringup_seq_tb_top.sv
module dac_bringup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_CYC   = 4;
    localparam int POLL_TO    = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fsc_valid = 1'b0;
    logic [15:0] fsc_ua = '0;
    logic        bus_req, bus_we, bus_ack, done, error;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  err_code;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;

    logic [7:0] mem [0:255];
    int log_a [0:63];
    int log_d [0:63];
    int log_c [0:63];
    int n_log = 0;
    int mu_set = 0, rx_set = 0, mu_ok = 0, rx_ok = 0;
    logic [7:0] rx_bad = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_bringup_seq #(
        .RST_HOLD_CYC(HOLD_CYC), .POLL_TIMEOUT_CYC(POLL_TO), .MAX_TRIES(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fsc_valid(fsc_valid),
        .fsc_ua(fsc_ua), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .error(error), .err_code(err_code)
    );

    function automatic logic [7:0] model_rd(logic [7:0] a);
        if (a == 8'h2A) return (mu_ok != 0 && mu_set >= mu_ok) ? 8'hF1 : 8'hF0;
        if (a == 8'h21) return (rx_ok != 0 && rx_set >= rx_ok) ? 8'h09 : rx_bad;
        return mem[a];
    endfunction

    // register target: acknowledges one cycle after a request is seen
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            bus_ack <= 1'b0;
            bus_rdata <= 8'h00;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                mem[bus_addr] = bus_wdata;
                if (n_log < 64) begin
                    log_a[n_log] = int'(bus_addr);
                    log_d[n_log] = int'(bus_wdata);
                    log_c[n_log] = cyc;
                    n_log = n_log + 1;
                end
                if (bus_addr == 8'h26 && bus_wdata[0]) mu_set = mu_set + 1;
                if (bus_addr == 8'h10 && bus_wdata[1:0] == 2'b11) rx_set = rx_set + 1;
            end else begin
                bus_rdata <= model_rd(bus_addr);
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int wr_count(int a);
        int n = 0;
        for (int i = 0; i < n_log; i++) if (log_a[i] == a) n++;
        return n;
    endfunction

    function automatic int wr_nth(int a, int nth, bit want_cyc);
        int n = 0;
        for (int i = 0; i < n_log; i++)
            if (log_a[i] == a) begin
                if (n == nth) return want_cyc ? log_c[i] : log_d[i];
                n++;
            end
        return -1;
    endfunction

    function automatic int exp_code(int ua);
        return ((10 * ua - 85800) * 2 + 226) / 452;
    endfunction

    task automatic run_seq(input int mu_at, input int rx_at, input logic [7:0] bad,
                           input bit vld, input int ua, input bit poke);
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h00] = 8'h01;
        mem[8'h13] = 8'hA5;
        mem[8'h07] = 8'hFC;
        n_log = 0; mu_set = 0; rx_set = 0;
        mu_ok = mu_at; rx_ok = rx_at; rx_bad = bad;
        fsc_valid = vld; fsc_ua = 16'(ua);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int w = 0; w < 20000 && !(done || error); w++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset error", int'(error), 0);
        chk("R1 reset err_code", int'(err_code), 0);
        chk("R1 reset bus_req", int'(bus_req), 0);
    endtask

    task automatic t_nominal;
        int ea [15] = '{'h00,'h00,'h22,'h23,'h24,'h25,'h27,'h28,'h29,'h26,'h13,'h10,'h10,'h06,'h07};
        int ed [15] = '{'h21,'h01,'h0F,'h0F,'h30,'h80,'h44,'h6C,'hCB,'h01,'hA2,'h00,'h03,'h00,'hFC};
        run_seq(1, 1, 8'h00, 1, 8580, 0);
        chk("R10 nominal done", int'(done), 1);
        chk("R10 nominal err_code", int'(err_code), 0);
        chk("R3 write count", n_log, 15);
        for (int i = 0; i < 15; i++) begin
            chk($sformatf("R3 order addr #%0d", i), log_a[i], ea[i]);
            chk($sformatf("R7 order data #%0d", i), log_d[i], ed[i]);
        end
        chk("R2 reset hold", int'((log_c[1] - log_c[0]) >= HOLD_CYC), 1);
        chk("R4 single mu try", wr_count('h29), 1);
    endtask

    task automatic t_codes;
        run_seq(1, 1, 8'h00, 1, 31700, 0);
        chk("R10 max low byte", wr_nth('h06, 0, 0), exp_code(31700) & 255);
        chk("R10 max high bits", wr_nth('h07, 0, 0), 'hFC | (exp_code(31700) >> 8));
        run_seq(1, 1, 8'h00, 1, 8592, 0);
        chk("R10 round-up low byte", wr_nth('h06, 0, 0), exp_code(8592));
        run_seq(1, 1, 8'h00, 1, 20000, 0);
        chk("R10 mid low byte", wr_nth('h06, 0, 0), exp_code(20000) & 255);
        chk("R10 mid high bits", wr_nth('h07, 0, 0), 'hFC | (exp_code(20000) >> 8));
    endtask

    task automatic t_mu_retry;
        run_seq(3, 1, 8'h00, 0, 0, 0);
        chk("R6 mu third try done", int'(done), 1);
        chk("R4 mu tries", wr_count('h29), 3);
    endtask

    task automatic t_mu_fail;
        run_seq(0, 1, 8'h00, 1, 10000, 0);
        chk("R6 mu fail error", int'(error), 1);
        chk("R6 mu fail code", int'(err_code), 1);
        chk("R6 mu tries", wr_count('h29), 3);
        chk("R6 no receiver write", wr_count('h13), 0);
        chk("R5 gap try1-2", int'((wr_nth('h29, 1, 1) - wr_nth('h29, 0, 1)) >= POLL_TO), 1);
        chk("R5 gap try2-3", int'((wr_nth('h29, 2, 1) - wr_nth('h29, 1, 1)) >= POLL_TO), 1);
    endtask

    task automatic t_rx;
        run_seq(1, 0, 8'h0B, 1, 10000, 0);
        chk("R8 near-lock error code", int'(err_code), 2);
        chk("R8 rx tries", wr_count('h13), 3);
        chk("R8 no current write", wr_count('h06), 0);
        run_seq(1, 2, 8'h08, 1, 10000, 0);
        chk("R8 rx second try done", int'(done), 1);
        chk("R7 rx loop writes", wr_count('h10), 4);
    endtask

    task automatic t_range;
        run_seq(1, 1, 8'h00, 1, 8579, 0);
        chk("R9 low error code", int'(err_code), 3);
        chk("R9 low no 0x06", wr_count('h06), 0);
        chk("R9 low no 0x07", wr_count('h07), 0);
        run_seq(1, 1, 8'h00, 1, 31701, 0);
        chk("R9 high error code", int'(err_code), 3);
        chk("R9 high no 0x06", wr_count('h06), 0);
    endtask

    task automatic t_no_fsc;
        run_seq(1, 1, 8'h00, 0, 2, 0);
        chk("R11 done without current", int'(done), 1);
        chk("R11 no 0x06", wr_count('h06), 0);
        chk("R11 no 0x07", wr_count('h07), 0);
    endtask

    task automatic t_busy_start;
        run_seq(1, 1, 8'h00, 1, 9000, 1);
        chk("R1 busy start reset writes", wr_count('h00), 2);
        chk("R1 busy start table writes", wr_count('h22), 1);
        chk("R1 busy start done", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nominal();
        t_codes();
        t_mu_retry();
        t_mu_fail();
        t_rx();
        t_range();
        t_no_fsc();
        t_busy_start();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule